// File: doc/BRIEF.md
# Per-Core Power Mode Controller

This block sets the power state of a cluster of processor cores, each paired with a local RAM. For every core, software writes a 3-bit mode code. The block turns that code into four registered enables: the core-and-RAM clock gate, the cache clock gate, the core supply switch and the local-RAM supply switch. There are five graded modes. Each deeper mode removes one more resource. In the second-deepest mode, the core is unpowered but its local RAM keeps its supply and so keeps its contents.

A change of mode runs in two steps so the switches are always used in a safe order. When a core goes to a deeper mode, its clock gates close at once and its supply switches open a fixed number of cycles later. When a core comes back to a shallower mode, its supplies return first and its clocks restart after a settle count. While a core is between the two steps, its busy flag is high and any new request for that core is dropped. A status field gives the mode each core has fully reached.

A write carries a per-core strobe vector and one mode field per core. Only the strobed cores act on their field.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: During reset and after its release, before any request, every core has all four enables high, busy low and status 0.
- R2: Mode codes and their final enables, written as {ram supply, core supply, cache clock, core clock}: 0 full run = 1111, 1 doze = 1110, 2 nap = 1100, 3 retain = 1000, 4 off = 0000. Status bits [3c+2:3c] hold core c's code once it is reached. Core supply is never on without RAM supply.
- R3: The codes 5, 6 and 7 act exactly like code 0.
- R4: For a request to a deeper (numerically larger) code, the clock enables take their target values on the edge that samples the request. The supply enables and status take theirs OFF_DLY (default 4) edges later.
- R5: For a request to a shallower code, the supply enables take their target values on the sampling edge. The clock enables and status take theirs SETTLE_DLY (default 3) edges later.
- R6: Busy for a core rises on the sampling edge of an accepted request and falls on the edge that applies the second step. Status does not change while busy is high, and enables do not change while the core is idle.
- R7: A request that reaches a core whose busy flag is high is dropped. The in-flight transition ends at its own target.
- R8: A request for the code a core already holds changes nothing and does not raise busy.
- R9: Only cores whose bit in the write strobe is set act on their field. The other cores are unaffected.
- R10: Neither clock enable of a core is high while that core's supply enable is low.
- R11: A core's clock enables and its supply enables never change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pm_wr_en | input | NUM_CORES | Per-core write strobe for the mode fields |
| pm_wr_data | input | 3*NUM_CORES | Mode code for core c in bits [3c+2:3c] |
| core_clk_en | output | NUM_CORES | Core and local-RAM clock enable per core |
| cache_clk_en | output | NUM_CORES | Cache clock enable per core |
| core_pwr_en | output | NUM_CORES | Core supply switch enable per core |
| ram_pwr_en | output | NUM_CORES | Local-RAM supply switch enable per core |
| pm_busy | output | NUM_CORES | Transition in progress per core |
| pm_status | output | 3*NUM_CORES | Mode fully reached by core c in bits [3c+2:3c] |

## Verification
A request sampled at edge E shows its first step (clocks for deeper moves, supplies for shallower ones) and the rising busy flag right after E. The second step, the new status and the falling busy flag appear after edge E+OFF_DLY or E+SETTLE_DLY. The driver stamps each expected item with the number of its due edge, which it takes from a bench cycle counter. The monitor compares only at the falling clock edge after that edge, and it checks the intermediate state one edge before completion. A dropped request or a no-change request is checked at the ports one edge after the in-flight transition would end, so any wrongly accepted change would be visible by then.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int PM_MODE_W = 3;

  typedef enum logic [PM_MODE_W-1:0] {
    PM_RUN    = 3'd0,
    PM_DOZE   = 3'd1,
    PM_NAP    = 3'd2,
    PM_RETAIN = 3'd3,
    PM_OFF    = 3'd4
  } pm_mode_e;

  typedef struct packed {
    logic ram_pwr;
    logic core_pwr;
    logic cache_clk;
    logic core_clk;
  } pm_en_t;

  // Codes above the deepest mode fall back to full run.
  function automatic pm_mode_e pm_legalize(input logic [PM_MODE_W-1:0] raw);
    pm_mode_e m;
    case (raw)
      3'd1:    m = PM_DOZE;
      3'd2:    m = PM_NAP;
      3'd3:    m = PM_RETAIN;
      3'd4:    m = PM_OFF;
      default: m = PM_RUN;
    endcase
    return m;
  endfunction

  function automatic pm_en_t pm_en_of(input pm_mode_e m);
    pm_en_t e;
    case (m)
      PM_DOZE:   e = '{ram_pwr:1'b1, core_pwr:1'b1, cache_clk:1'b1, core_clk:1'b0};
      PM_NAP:    e = '{ram_pwr:1'b1, core_pwr:1'b1, cache_clk:1'b0, core_clk:1'b0};
      PM_RETAIN: e = '{ram_pwr:1'b1, core_pwr:1'b0, cache_clk:1'b0, core_clk:1'b0};
      PM_OFF:    e = '{ram_pwr:1'b0, core_pwr:1'b0, cache_clk:1'b0, core_clk:1'b0};
      default:   e = '{ram_pwr:1'b1, core_pwr:1'b1, cache_clk:1'b1, core_clk:1'b1};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pmc_req_decode.sv
module pmc_req_decode
  import pmc_pkg::*;
#(
  parameter int NUM_CORES = 8
) (
  input  logic [NUM_CORES-1:0]           wr_en,
  input  logic [PM_MODE_W*NUM_CORES-1:0] wr_data,
  output logic [NUM_CORES-1:0]           req_vld,
  output logic [PM_MODE_W*NUM_CORES-1:0] req_mode
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_dec
    assign req_mode[c*PM_MODE_W +: PM_MODE_W] = pm_legalize(wr_data[c*PM_MODE_W +: PM_MODE_W]);
  end
  assign req_vld = wr_en;
endmodule

// File: rtl/pmc_core_seq.sv
module pmc_core_seq
  import pmc_pkg::*;
#(
  parameter int OFF_DLY    = 4,
  parameter int SETTLE_DLY = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_vld,
  input  pm_mode_e req_mode,
  output pm_en_t   en,
  output logic     busy,
  output pm_mode_e cur_mode
);
  localparam int MAX_DLY = (OFF_DLY > SETTLE_DLY) ? OFF_DLY : SETTLE_DLY;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);

  pm_mode_e   cur_q, cur_d, tgt_q, tgt_d;
  pm_en_t     en_q, en_d, tgt_en, req_en;
  logic       busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic       accept, deeper, st_ld;

  assign req_en = pm_en_of(req_mode);
  assign tgt_en = pm_en_of(tgt_q);
  assign deeper = (req_mode > cur_q);
  assign accept = !busy_q && req_vld && (req_mode != cur_q);
  assign st_ld  = accept || busy_q;

  always_comb begin
    cur_d  = cur_q;
    tgt_d  = tgt_q;
    en_d   = en_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      tgt_d  = req_mode;
      if (deeper) begin
        en_d.core_clk  = req_en.core_clk;
        en_d.cache_clk = req_en.cache_clk;
        cnt_d          = CNT_W'(OFF_DLY);
      end else begin
        en_d.core_pwr  = req_en.core_pwr;
        en_d.ram_pwr   = req_en.ram_pwr;
        cnt_d          = CNT_W'(SETTLE_DLY);
      end
    end else if (busy_q) begin
      if (cnt_q == CNT_W'(1)) begin
        en_d   = tgt_en;
        cur_d  = tgt_q;
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= PM_RUN;
      tgt_q  <= PM_RUN;
      en_q   <= '1;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (st_ld) begin
      cur_q  <= cur_d;
      tgt_q  <= tgt_d;
      en_q   <= en_d;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign en       = en_q;
  assign busy     = busy_q;
  assign cur_mode = cur_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_CORES  = 8,
  parameter int OFF_DLY    = 4,
  parameter int SETTLE_DLY = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CORES-1:0]           pm_wr_en,
  input  logic [PM_MODE_W*NUM_CORES-1:0] pm_wr_data,
  output logic [NUM_CORES-1:0]           core_clk_en,
  output logic [NUM_CORES-1:0]           cache_clk_en,
  output logic [NUM_CORES-1:0]           core_pwr_en,
  output logic [NUM_CORES-1:0]           ram_pwr_en,
  output logic [NUM_CORES-1:0]           pm_busy,
  output logic [PM_MODE_W*NUM_CORES-1:0] pm_status
);
  logic                           rst_sync_n;
  logic [NUM_CORES-1:0]           req_vld;
  logic [PM_MODE_W*NUM_CORES-1:0] req_mode;

  pmc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pmc_req_decode #(.NUM_CORES(NUM_CORES)) u_dec (
    .wr_en(pm_wr_en), .wr_data(pm_wr_data), .req_vld(req_vld), .req_mode(req_mode)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    pm_en_t   en;
    pm_mode_e cur;
    pmc_core_seq #(.OFF_DLY(OFF_DLY), .SETTLE_DLY(SETTLE_DLY)) u_seq (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .req_vld  (req_vld[c]),
      .req_mode (pm_mode_e'(req_mode[c*PM_MODE_W +: PM_MODE_W])),
      .en       (en),
      .busy     (pm_busy[c]),
      .cur_mode (cur)
    );
    assign core_clk_en[c]  = en.core_clk;
    assign cache_clk_en[c] = en.cache_clk;
    assign core_pwr_en[c]  = en.core_pwr;
    assign ram_pwr_en[c]   = en.ram_pwr;
    assign pm_status[c*PM_MODE_W +: PM_MODE_W] = cur;
  end
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int NUM_CORES = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CORES-1:0]   core_clk_en,
  input logic [NUM_CORES-1:0]   cache_clk_en,
  input logic [NUM_CORES-1:0]   core_pwr_en,
  input logic [NUM_CORES-1:0]   ram_pwr_en,
  input logic [NUM_CORES-1:0]   pm_busy,
  input logic [3*NUM_CORES-1:0] pm_status
);
  for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
    a_r10_core_clk_needs_pwr: assert property (@(posedge clk) disable iff (!rst_n)
      core_clk_en[i] |-> core_pwr_en[i]);
    a_r10_cache_clk_needs_pwr: assert property (@(posedge clk) disable iff (!rst_n)
      cache_clk_en[i] |-> core_pwr_en[i]);
    a_r2_core_pwr_needs_ram: assert property (@(posedge clk) disable iff (!rst_n)
      core_pwr_en[i] |-> ram_pwr_en[i]);
    a_r11_no_joint_step: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({core_clk_en[i], cache_clk_en[i]}) |-> $stable({core_pwr_en[i], ram_pwr_en[i]}));
    a_r6_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      pm_busy[i] |-> $stable(pm_status[i*3 +: 3]));
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!pm_busy[i] && !$past(pm_busy[i])) |->
        $stable({core_clk_en[i], cache_clk_en[i], core_pwr_en[i], ram_pwr_en[i]}));
    a_r4_clk_before_pwr_off: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(core_pwr_en[i]) |-> (!$past(core_clk_en[i]) && !$past(cache_clk_en[i])));
    a_r5_pwr_before_clk_on: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cache_clk_en[i]) |-> $past(core_pwr_en[i]));
  end
endmodule

bind pwr_mode_ctrl pmc_checker #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .core_clk_en(core_clk_en), .cache_clk_en(cache_clk_en),
  .core_pwr_en(core_pwr_en), .ram_pwr_en(ram_pwr_en),
  .pm_busy(pm_busy), .pm_status(pm_status)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  localparam int N      = 8;
  localparam int OFF    = 4;
  localparam int SETTLE = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   pm_wr_en = '0;
  logic [3*N-1:0] pm_wr_data = '0;
  logic [N-1:0]   core_clk_en, cache_clk_en, core_pwr_en, ram_pwr_en, pm_busy;
  logic [3*N-1:0] pm_status;

  pwr_mode_ctrl #(.NUM_CORES(N), .OFF_DLY(OFF), .SETTLE_DLY(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .pm_wr_en(pm_wr_en), .pm_wr_data(pm_wr_data),
    .core_clk_en(core_clk_en), .cache_clk_en(cache_clk_en),
    .core_pwr_en(core_pwr_en), .ram_pwr_en(ram_pwr_en),
    .pm_busy(pm_busy), .pm_status(pm_status)
  );

  always #4 clk = ~clk;

  typedef struct {
    int       due;
    int       core;
    logic [3:0] en;
    logic     busy;
    logic [2:0] stat;
    string    tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int model_mode [N];
  int done_cyc [N];
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // {ram supply, core supply, cache clock, core clock} per R2
  function automatic logic [3:0] exp_en(input int m);
    case (m)
      1: return 4'b1110;
      2: return 4'b1100;
      3: return 4'b1000;
      4: return 4'b0000;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic int legal(input logic [2:0] raw);
    return (raw > 3'd4) ? 0 : int'(raw);
  endfunction

  task automatic push(input int due, input int c, input logic [3:0] en,
                      input logic b, input int st, input string tag);
    item_t it;
    it.due = due; it.core = c; it.en = en; it.busy = b; it.stat = 3'(st); it.tag = tag;
    q.push_back(it);
  endtask

  // Driver: called at a falling edge; the request is sampled at the next rising edge.
  task automatic issue(input logic [N-1:0] mask, input logic [3*N-1:0] data, input string tag);
    int e;
    e = cyc + 1;
    for (int c = 0; c < N; c++) begin
      if (mask[c]) begin
        int d, m;
        d = legal(data[c*3 +: 3]);
        m = model_mode[c];
        if (e <= done_cyc[c]) begin
          push(done_cyc[c] + 1, c, exp_en(m), 1'b0, m, {tag, " R7 dropped"});
        end else if (d == m) begin
          push(e, c, exp_en(m), 1'b0, m, {tag, " R8 same mode"});
          push(e + OFF, c, exp_en(m), 1'b0, m, {tag, " R8 still idle"});
        end else if (d > m) begin
          push(e, c, {exp_en(m)[3:2], exp_en(d)[1:0]}, 1'b1, m, {tag, " R4 clocks first"});
          push(e + OFF - 1, c, {exp_en(m)[3:2], exp_en(d)[1:0]}, 1'b1, m, {tag, " R6 still busy"});
          push(e + OFF, c, exp_en(d), 1'b0, d, {tag, " R4 supplies after delay"});
          model_mode[c] = d;
          done_cyc[c] = e + OFF;
        end else begin
          push(e, c, {exp_en(d)[3:2], exp_en(m)[1:0]}, 1'b1, m, {tag, " R5 supplies first"});
          push(e + SETTLE - 1, c, {exp_en(d)[3:2], exp_en(m)[1:0]}, 1'b1, m, {tag, " R6 still busy"});
          push(e + SETTLE, c, exp_en(d), 1'b0, d, {tag, " R5 clocks after settle"});
          model_mode[c] = d;
          done_cyc[c] = e + SETTLE;
        end
      end
    end
    pm_wr_en = mask;
    pm_wr_data = data;
    @(negedge clk);
    pm_wr_en = '0;
  endtask

  function automatic logic [3*N-1:0] field(input int c, input logic [2:0] v);
    logic [3*N-1:0] d;
    d = '0;
    d[c*3 +: 3] = v;
    return d;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      for (int k = q.size() - 1; k >= 0; k--) begin
        if (q[k].due <= cyc) begin
          int c;
          logic [3:0] a_en;
          logic a_b;
          logic [2:0] a_st;
          c = q[k].core;
          a_en = {ram_pwr_en[c], core_pwr_en[c], cache_clk_en[c], core_clk_en[c]};
          a_b = pm_busy[c];
          a_st = pm_status[c*3 +: 3];
          n_checks++;
          if (q[k].due < cyc) begin
            n_fail++;
            $display("FAIL %s core%0d: item missed due=%0d now=%0d", q[k].tag, c, q[k].due, cyc);
          end else if (a_en !== q[k].en || a_b !== q[k].busy || a_st !== q[k].stat) begin
            n_fail++;
            $display("FAIL %s core%0d cyc%0d: actual en=%b busy=%b stat=%0d expected en=%b busy=%b stat=%0d",
                     q[k].tag, c, cyc, a_en, a_b, a_st, q[k].en, q[k].busy, q[k].stat);
          end
          q.delete(k);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < N; c++) begin
      model_mode[c] = 0;
      done_cyc[c] = -1;
    end
    // R1: state while reset is held
    idle(2);
    n_checks++;
    if ({core_clk_en, cache_clk_en, core_pwr_en, ram_pwr_en} !== '1 || pm_busy !== '0 || pm_status !== '0) begin
      n_fail++;
      $display("FAIL R1 in reset: actual busy=%b stat=%h expected busy=0 stat=0", pm_busy, pm_status);
    end
    rst_n = 1'b1;
    idle(4);
    for (int c = 0; c < N; c++) push(cyc + 1, c, 4'b1111, 1'b0, 0, "R1 after reset");
    idle(2);

    // R2/R4/R5: core 0 through doze, off and back to run
    issue(8'h01, field(0, 3'd1), "R2 c0 run->doze");
    idle(OFF + 2);
    issue(8'h01, field(0, 3'd4), "R2 c0 doze->off");
    idle(OFF + 2);
    issue(8'h01, field(0, 3'd0), "R2 c0 off->run");
    idle(SETTLE + 2);

    // Core 1: retain then shallower to nap
    issue(8'h02, field(1, 3'd3), "R2 c1 run->retain");
    idle(OFF + 2);
    issue(8'h02, field(1, 3'd2), "R5 c1 retain->nap");
    idle(SETTLE + 2);

    // Core 2: R3 codes above 4 act as run
    issue(8'h04, field(2, 3'd6), "R3 c2 code6 at run");
    idle(OFF + 2);
    issue(8'h04, field(2, 3'd2), "R2 c2 run->nap");
    idle(OFF + 2);
    issue(8'h04, field(2, 3'd7), "R3 c2 code7 from nap");
    idle(SETTLE + 2);

    // Core 3: R7 second request while busy is dropped
    issue(8'h08, field(3, 3'd4), "R7 c3 run->off");
    issue(8'h08, field(3, 3'd1), "R7 c3 doze during busy");
    idle(OFF + 2);

    // R9: cores 4..7 together, core 3 field present but strobe clear
    issue(8'hF0, {3'd1, 3'd2, 3'd3, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0} | field(3, 3'd0),
          "R9 group write");
    push(cyc + OFF, 3, exp_en(model_mode[3]), 1'b0, model_mode[3], "R9 c3 unstrobed unaffected");
    idle(OFF + 2);
    issue(8'hF0, {3'd0, 3'd0, 3'd0, 3'd0, 12'd0}, "R5 group back to run");
    idle(OFF + 4);

    while (q.size() != 0) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule